// File: doc/BRIEF.md
# DMA Channel Interrupt Coalescing Control and Status Unit

This block holds the control and status state of one channel of a descriptor-driven DMA engine. Software reaches it through a 32-bit word-addressed register port. The transfer engine reaches it through plain pulse inputs: one pulse for each finished packet, and one pulse each for "halted", "idle" and "error" conditions. The block drives the channel's run, halted and idle indications and a single interrupt line.

Completion interrupts are coalesced in two ways. The first is a down-counter that raises the completion flag only after a programmed number of packets. The second is a delay timer that every packet restarts, and that raises a delay flag once the channel has gone quiet for a programmed time. Flags clear when software writes a one to them. A soft reset returns the channel to its power-up state. The reset bit reads back as set exactly once, so software can poll for the end of the reset.

Word 0 holds control and word 1 holds status. Every other word reads as zero. A read request is answered one cycle later with a valid strobe. There is no back-pressure on either side, so every pulse and every access is taken in the cycle it is presented.

Top module: `dma_coalesce_csr`

## Requirements
- R1: After hardware reset, run_o is 0, halted_o is 1, idle_o is 0 and irq_o is 0. Control (word 0) reads 0x0001_0002 and status (word 1) reads 0x0001_0001.
- R2: Control bit 1 always reads 1, whatever value is written. Control bits 15 and [11:3] read 0. Status bits 15 and [11:2] read 0. Any word address other than 0 or 1 reads 0.
- R3: A control write with bit 0 set and bit 2 clear, made while no soft reset is pending, clears halted (status bit 0) and idle (status bit 1). run_o follows control bit 0.
- R4: Every control write loads the completion counter from the written bits [23:16]. Status bits [23:16] show the remaining count.
- R5: Each pkt_done pulse decrements the counter. When the result is zero, the completion flag (status bit 12) sets and the counter reloads from control bits [23:16].
- R6: A pkt_done pulse with a nonzero control delay field [31:24] restarts the timer at that value. A zero delay field leaves the timer alone. The timer, shown in status bits [31:24], decrements every PRESC_DIV cycles. On the step from 1 to 0 it sets the delay flag (status bit 13) and reloads the counter. It then stays at 0.
- R7: irq_o is high when any status flag in bits [14:12] is set together with the matching enable in control bits [14:12].
- R8: Writing ones to status bits [14:12] clears those flags. Zero bits and all other status bits are not affected by the write.
- R9: When a flag's set event and its write-one-to-clear arrive in the same cycle, the flag ends up set.
- R10: A control write with bit 2 set restores the control, counter, timer and status values of R1. Reading control then returns bit 2 as 1 once, and 0 on later reads. Until that read, every control write re-applies the reset, and a run request does not clear halted.
- R11: The eng_halt_set, eng_idle_set and eng_err_set pulses set status bit 0, bit 1 and bit 14 respectively.
- R12: csr_rvalid is high exactly one cycle after each cycle with csr_rd_en high. csr_rdata then holds the word selected by the address in the request cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| csr_wr_en | input | 1 | Register write strobe |
| csr_rd_en | input | 1 | Register read strobe |
| csr_addr | input | ADDR_W | Word address |
| csr_wdata | input | 32 | Write data |
| csr_rdata | output | 32 | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read data valid, one cycle after csr_rd_en |
| pkt_done | input | 1 | One-cycle pulse for each completed packet |
| eng_halt_set | input | 1 | Engine request to set halted |
| eng_idle_set | input | 1 | Engine request to set idle |
| eng_err_set | input | 1 | Engine request to set the error flag |
| run_o | output | 1 | Channel run enable |
| halted_o | output | 1 | Channel halted indication |
| idle_o | output | 1 | Channel idle indication |
| irq_o | output | 1 | Channel interrupt |

## Verification
The hardest state to reach from the ports is a set event and a clear landing on the same flag in the same cycle. The other hard case is reading the delay timer partway through its countdown. The bench raises pkt_done and a clearing status write in one cycle, which covers the collision. It then counts exact cycles from a packet pulse, so that a status read samples the timer just after one prescaler step and before the next. A later read shows the expiry together with the counter reload. A control write sent while a soft reset is still pending covers the reset-retention path.

// File: rtl/dcr_pkg.sv
package dcr_pkg;
  localparam int unsigned WORD_W    = 32;
  localparam int unsigned CNT_W     = 8;
  localparam int unsigned TMR_W     = 8;
  localparam int unsigned NFLAGS    = 3;
  localparam int unsigned RUN_BIT   = 0;
  localparam int unsigned TAIL_BIT  = 1;
  localparam int unsigned SRST_BIT  = 2;
  localparam int unsigned FLAG_LSB  = 12;
  localparam int unsigned THR_LSB   = 16;
  localparam int unsigned DLY_LSB   = 24;
  localparam int unsigned CTRL_WORD = 0;
  localparam int unsigned STAT_WORD = 1;
  localparam int unsigned FLG_CMPL  = 0;
  localparam int unsigned FLG_DLY   = 1;
  localparam int unsigned FLG_ERR   = 2;

  typedef struct packed {
    logic [TMR_W-1:0]  dly;
    logic [CNT_W-1:0]  thr;
    logic [NFLAGS-1:0] en;
    logic              run;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{dly: '0, thr: CNT_W'(1), en: '0, run: 1'b0};
endpackage

// File: rtl/dcr_ctrl_reg.sv
module dcr_ctrl_reg
  import dcr_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr_ctrl,
  input  logic  rd_ctrl,
  input  logic  wr_srst,
  input  ctrl_t wr_fields,
  output ctrl_t ctrl_q,
  output logic  srst_pend_q,
  output logic  eff_srst,
  output logic  run_start
);
  // A pending reset is kept across writes, so each write re-applies it
  assign eff_srst  = wr_ctrl & (wr_srst | srst_pend_q);
  assign run_start = wr_ctrl & wr_fields.run & ~eff_srst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q      <= CTRL_RST;
      srst_pend_q <= 1'b0;
    end else if (eff_srst) begin
      ctrl_q      <= CTRL_RST;
      srst_pend_q <= 1'b1;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_fields;
      if (rd_ctrl) srst_pend_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dcr_coalesce.sv
module dcr_coalesce #(
  parameter int unsigned PRESC_DIV = 4,
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned TMR_W     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             reload,
  input  logic [CNT_W-1:0] thr_new,
  input  logic [CNT_W-1:0] thr_live,
  input  logic [TMR_W-1:0] dly_live,
  input  logic             pkt_done,
  output logic [CNT_W-1:0] cnt_q,
  output logic [TMR_W-1:0] tmr_q,
  output logic             ioc_set,
  output logic             dly_set
);
  localparam int unsigned PW = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PRESC_DIV - 1);

  logic [PW-1:0]    presc_q;
  logic [CNT_W-1:0] cnt_dec;
  logic             tick;
  logic             restart;

  assign cnt_dec = cnt_q - CNT_W'(1);
  assign tick    = (tmr_q != '0) && (presc_q == PRESC_LAST);
  assign restart = pkt_done && (dly_live != '0);
  assign ioc_set = pkt_done && !clear && !reload && (cnt_dec == '0);
  assign dly_set = tick && (tmr_q == TMR_W'(1)) && !restart && !clear;

  // completion counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= CNT_W'(1);
    else if (clear)    cnt_q <= CNT_W'(1);
    else if (reload)   cnt_q <= thr_new;
    else if (dly_set)  cnt_q <= thr_live;
    else if (pkt_done) cnt_q <= (cnt_dec == '0) ? thr_live : cnt_dec;
  end

  // delay timer with prescaler
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q   <= '0;
      presc_q <= '0;
    end else if (clear) begin
      tmr_q   <= '0;
      presc_q <= '0;
    end else if (restart) begin
      tmr_q   <= dly_live;
      presc_q <= '0;
    end else if (tick) begin
      tmr_q   <= tmr_q - TMR_W'(1);
      presc_q <= '0;
    end else if (tmr_q != '0) begin
      presc_q <= presc_q + PW'(1);
    end
  end
endmodule

// File: rtl/dcr_status.sv
module dcr_status #(
  parameter int unsigned NFLAGS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              run_start,
  input  logic              halt_set,
  input  logic              idle_set,
  input  logic [NFLAGS-1:0] flag_set,
  input  logic [NFLAGS-1:0] flag_w1c,
  input  logic [NFLAGS-1:0] flag_en,
  output logic              halted_q,
  output logic              idle_q,
  output logic [NFLAGS-1:0] flags_q,
  output logic              irq
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           flags_q[i] <= 1'b0;
      else if (clear)       flags_q[i] <= 1'b0;
      else if (flag_set[i]) flags_q[i] <= 1'b1;
      else if (flag_w1c[i]) flags_q[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
    end else if (clear) begin
      halted_q <= 1'b1;
      idle_q   <= 1'b0;
    end else begin
      if (halt_set)       halted_q <= 1'b1;
      else if (run_start) halted_q <= 1'b0;
      if (idle_set)       idle_q <= 1'b1;
      else if (run_start) idle_q <= 1'b0;
    end
  end

  assign irq = |(flags_q & flag_en);
endmodule

// File: rtl/dma_coalesce_csr.sv
module dma_coalesce_csr
  import dcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned PRESC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_wr_en,
  input  logic              csr_rd_en,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              csr_rvalid,
  input  logic              pkt_done,
  input  logic              eng_halt_set,
  input  logic              eng_idle_set,
  input  logic              eng_err_set,
  output logic              run_o,
  output logic              halted_o,
  output logic              idle_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(CTRL_WORD);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(STAT_WORD);

  logic              wr_ctrl, wr_stat, rd_ctrl;
  ctrl_t             wr_fields, ctrl_q;
  logic              srst_pend_q, eff_srst, run_start;
  logic [CNT_W-1:0]  cnt_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              ioc_set, dly_set;
  logic [NFLAGS-1:0] flags_q, flag_set, flag_w1c;
  logic              halted_q, idle_q, irq;
  logic [WORD_W-1:0] ctrl_word, stat_word, rd_mux;
  logic              unused_wdata;

  assign wr_ctrl = csr_wr_en && (csr_addr == A_CTRL);
  assign wr_stat = csr_wr_en && (csr_addr == A_STAT);
  assign rd_ctrl = csr_rd_en && (csr_addr == A_CTRL);

  assign wr_fields.dly = csr_wdata[DLY_LSB +: TMR_W];
  assign wr_fields.thr = csr_wdata[THR_LSB +: CNT_W];
  assign wr_fields.en  = csr_wdata[FLAG_LSB +: NFLAGS];
  assign wr_fields.run = csr_wdata[RUN_BIT];
  assign unused_wdata  = ^{csr_wdata[15], csr_wdata[11:3], csr_wdata[TAIL_BIT]};

  dcr_ctrl_reg u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_ctrl     (wr_ctrl),
    .rd_ctrl     (rd_ctrl),
    .wr_srst     (csr_wdata[SRST_BIT]),
    .wr_fields   (wr_fields),
    .ctrl_q      (ctrl_q),
    .srst_pend_q (srst_pend_q),
    .eff_srst    (eff_srst),
    .run_start   (run_start)
  );

  dcr_coalesce #(
    .PRESC_DIV (PRESC_DIV),
    .CNT_W     (CNT_W),
    .TMR_W     (TMR_W)
  ) u_coal (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (eff_srst),
    .reload   (wr_ctrl),
    .thr_new  (wr_fields.thr),
    .thr_live (ctrl_q.thr),
    .dly_live (ctrl_q.dly),
    .pkt_done (pkt_done),
    .cnt_q    (cnt_q),
    .tmr_q    (tmr_q),
    .ioc_set  (ioc_set),
    .dly_set  (dly_set)
  );

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_CMPL] = ioc_set;
    flag_set[FLG_DLY]  = dly_set;
    flag_set[FLG_ERR]  = eng_err_set;
  end
  assign flag_w1c = wr_stat ? csr_wdata[FLAG_LSB +: NFLAGS] : '0;

  dcr_status #(.NFLAGS(NFLAGS)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (eff_srst),
    .run_start (run_start),
    .halt_set  (eng_halt_set),
    .idle_set  (eng_idle_set),
    .flag_set  (flag_set),
    .flag_w1c  (flag_w1c),
    .flag_en   (ctrl_q.en),
    .halted_q  (halted_q),
    .idle_q    (idle_q),
    .flags_q   (flags_q),
    .irq       (irq)
  );

  assign ctrl_word = {ctrl_q.dly, ctrl_q.thr, 1'b0, ctrl_q.en, 9'b0,
                      srst_pend_q, 1'b1, ctrl_q.run};
  assign stat_word = {tmr_q, cnt_q, 1'b0, flags_q, 10'b0, idle_q, halted_q};

  always_comb begin
    if (csr_addr == A_CTRL)      rd_mux = ctrl_word;
    else if (csr_addr == A_STAT) rd_mux = stat_word;
    else                         rd_mux = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      csr_rdata  <= '0;
      csr_rvalid <= 1'b0;
    end else begin
      csr_rvalid <= csr_rd_en;
      if (csr_rd_en) csr_rdata <= rd_mux;
    end
  end

  assign run_o    = ctrl_q.run;
  assign halted_o = halted_q;
  assign idle_o   = idle_q;
  assign irq_o    = irq;
endmodule

// File: rtl/dma_coalesce_csr_chk.sv
module dma_coalesce_csr_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned CNT_W  = 8,
  parameter int unsigned TMR_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_ctrl,
  input logic              wr_run,
  input logic              wr_srst,
  input logic              srst_pend_q,
  input logic              eng_halt_set,
  input logic              csr_rd_en,
  input logic [ADDR_W-1:0] csr_addr,
  input logic              csr_rvalid,
  input logic              rd_tail,
  input logic              pkt_done,
  input logic              ioc_set,
  input logic              cmpl_flag,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [CNT_W-1:0]  thr,
  input logic [TMR_W-1:0]  tmr_q,
  input logic              run_o,
  input logic              halted_o,
  input logic              irq_o
);
  // R3
  run_clears_halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_run && !wr_srst && !srst_pend_q && !eng_halt_set) |=> !halted_o);

  // R10
  soft_rst_halts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_srst) |=> (halted_o && !run_o && !irq_o));

  // R12
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rd_en |=> csr_rvalid);

  // R12
  no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !csr_rd_en |=> !csr_rvalid);

  // R2
  tail_reads_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_rd_en && csr_addr == '0) |=> rd_tail);

  // R5
  cnt_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_set |=> (cnt_q == $past(thr)));

  // R9
  cmpl_flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_set |=> cmpl_flag);

  // R6
  timer_stays_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == '0 && !pkt_done) |=> (tmr_q == '0));
endmodule

bind dma_coalesce_csr dma_coalesce_csr_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (dcr_pkg::CNT_W),
  .TMR_W  (dcr_pkg::TMR_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_ctrl      (wr_ctrl),
  .wr_run       (csr_wdata[0]),
  .wr_srst      (csr_wdata[2]),
  .srst_pend_q  (srst_pend_q),
  .eng_halt_set (eng_halt_set),
  .csr_rd_en    (csr_rd_en),
  .csr_addr     (csr_addr),
  .csr_rvalid   (csr_rvalid),
  .rd_tail      (csr_rdata[1]),
  .pkt_done     (pkt_done),
  .ioc_set      (ioc_set),
  .cmpl_flag    (flags_q[0]),
  .cnt_q        (cnt_q),
  .thr          (ctrl_q.thr),
  .tmr_q        (tmr_q),
  .run_o        (run_o),
  .halted_o     (halted_o),
  .irq_o        (irq_o)
);

// File: tb/tb_dma_coalesce_csr.sv
module tb_dma_coalesce_csr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_wr_en = 1'b0;
  logic        csr_rd_en = 1'b0;
  logic [3:0]  csr_addr = '0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        csr_rvalid;
  logic        pkt_done = 1'b0;
  logic        eng_halt_set = 1'b0;
  logic        eng_idle_set = 1'b0;
  logic        eng_err_set = 1'b0;
  logic        run_o, halted_o, idle_o, irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  dma_coalesce_csr #(.ADDR_W(4), .PRESC_DIV(4)) dut (
    .clk(clk), .rst_n(rst_n),
    .csr_wr_en(csr_wr_en), .csr_rd_en(csr_rd_en), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .csr_rvalid(csr_rvalid),
    .pkt_done(pkt_done), .eng_halt_set(eng_halt_set),
    .eng_idle_set(eng_idle_set), .eng_err_set(eng_err_set),
    .run_o(run_o), .halted_o(halted_o), .idle_o(idle_o), .irq_o(irq_o)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: compare every returned read word
  always @(negedge clk) begin
    if (rst_n && csr_rvalid) begin
      if (exp_q.size() == 0) begin
        n_checks++;
        n_fail++;
        $display("FAIL R12: read data 0x%08h with no request pending, expected none", csr_rdata);
      end else begin
        check(tag_q.pop_front(), csr_rdata, exp_q.pop_front());
      end
    end
  end

  // all driver tasks start and end at a falling edge
  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    csr_wr_en = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk);
    csr_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    csr_rd_en = 1'b1; csr_addr = a;
    @(negedge clk);
    csr_rd_en = 1'b0;
  endtask

  task automatic pulse_pkt();
    pkt_done = 1'b1;
    @(negedge clk);
    pkt_done = 1'b0;
  endtask

  task automatic idle_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 run_o", 32'(run_o), 32'd0);
    check("R1 halted_o", 32'(halted_o), 32'd1);
    check("R1 idle_o", 32'(idle_o), 32'd0);
    check("R1 irq_o", 32'(irq_o), 32'd0);
    rd(4'd0, 32'h0001_0002, "R1 control");
    rd(4'd1, 32'h0001_0001, "R1 status");
    rd(4'd5, 32'h0000_0000, "R2 unmapped word");

    // R2 tail bit forced, reserved bits dropped
    wr(4'd0, 32'h0000_8FF8);
    rd(4'd0, 32'h0000_0002, "R2 control readback");

    // R3 run, R4 threshold load
    wr(4'd0, 32'h0003_7001);
    check("R3 run_o", 32'(run_o), 32'd1);
    check("R3 halted_o", 32'(halted_o), 32'd0);
    rd(4'd0, 32'h0003_7003, "R3 control");
    rd(4'd1, 32'h0003_0000, "R4 status count");

    // R5 countdown to completion flag
    pulse_pkt();
    pulse_pkt();
    rd(4'd1, 32'h0001_0000, "R5 count after two");
    check("R5 irq before threshold", 32'(irq_o), 32'd0);
    pulse_pkt();
    rd(4'd1, 32'h0003_1000, "R5 flag and reload");
    check("R7 irq enabled", 32'(irq_o), 32'd1);

    // R8 write one to clear
    wr(4'd1, 32'h0000_0000);
    rd(4'd1, 32'h0003_1000, "R8 zero write keeps flag");
    wr(4'd1, 32'h0000_1000);
    rd(4'd1, 32'h0003_0000, "R8 flag cleared");
    check("R8 irq after clear", 32'(irq_o), 32'd0);

    // R7 masking
    wr(4'd0, 32'h0001_0001);
    pulse_pkt();
    rd(4'd1, 32'h0001_1000, "R7 masked flag");
    check("R7 irq masked", 32'(irq_o), 32'd0);
    wr(4'd0, 32'h0001_1001);
    check("R7 irq unmasked", 32'(irq_o), 32'd1);
    wr(4'd1, 32'h0000_7000);
    check("R7 irq after clear", 32'(irq_o), 32'd0);

    // R9 set and clear in the same cycle
    pkt_done = 1'b1;
    csr_wr_en = 1'b1; csr_addr = 4'd1; csr_wdata = 32'h0000_1000;
    @(negedge clk);
    pkt_done = 1'b0; csr_wr_en = 1'b0;
    rd(4'd1, 32'h0001_1000, "R9 set wins");
    check("R9 irq", 32'(irq_o), 32'd1);
    wr(4'd1, 32'h0000_1000);

    // R6 delay timer, prescaler 4
    wr(4'd0, 32'h0305_2001);
    pulse_pkt();
    rd(4'd1, 32'h0304_0000, "R6 timer restarted");
    idle_cycles(3);
    rd(4'd1, 32'h0204_0000, "R6 timer one step");
    check("R6 irq before expiry", 32'(irq_o), 32'd0);
    idle_cycles(10);
    rd(4'd1, 32'h0005_2000, "R6 expiry flag and reload");
    check("R6 irq on expiry", 32'(irq_o), 32'd1);
    wr(4'd1, 32'h0000_2000);
    wr(4'd0, 32'h0005_2001);
    pulse_pkt();
    idle_cycles(20);
    rd(4'd1, 32'h0004_0000, "R6 zero delay no timer");

    // R11 engine set requests
    eng_halt_set = 1'b1;
    @(negedge clk);
    eng_halt_set = 1'b0;
    check("R11 halted_o", 32'(halted_o), 32'd1);
    eng_idle_set = 1'b1;
    @(negedge clk);
    eng_idle_set = 1'b0;
    check("R11 idle_o", 32'(idle_o), 32'd1);
    eng_err_set = 1'b1;
    @(negedge clk);
    eng_err_set = 1'b0;
    rd(4'd1, 32'h0004_4003, "R11 status");
    wr(4'd0, 32'h0004_4001);
    check("R3 rerun halted_o", 32'(halted_o), 32'd0);
    check("R3 rerun idle_o", 32'(idle_o), 32'd0);
    check("R7 error irq", 32'(irq_o), 32'd1);

    // R10 soft reset
    wr(4'd0, 32'h0000_0005);
    check("R10 run_o", 32'(run_o), 32'd0);
    check("R10 halted_o", 32'(halted_o), 32'd1);
    check("R10 irq_o", 32'(irq_o), 32'd0);
    wr(4'd0, 32'h0005_0001);
    check("R10 run ignored while pending", 32'(halted_o), 32'd1);
    check("R10 run_o while pending", 32'(run_o), 32'd0);
    rd(4'd0, 32'h0001_0006, "R10 reset bit seen once");
    rd(4'd0, 32'h0001_0002, "R10 reset bit cleared");
    wr(4'd0, 32'h0001_0001);
    check("R10 run after reset", 32'(halted_o), 32'd0);
    rd(4'd1, 32'h0001_0000, "R10 status after reset");

    // R12 all reads answered, no stray valid
    @(negedge clk);
    check("R12 rvalid idle", 32'(csr_rvalid), 32'd0);
    check("R12 pending reads", 32'(exp_q.size()), 32'd0);

    finish_run();
  end
endmodule